// File: doc/BRIEF.md
# Dual-Mode Asynchronous Register Bus Interface

This block connects a microprocessor bus to a small bank of 8-bit configuration registers. The processor side has no clock. The block samples every strobe into its own clock domain and finds the edges there. The same group of pins can carry two bus protocols. The first protocol has separate active-low read and write strobes. The second has a single data strobe together with a read/write qualifier. A static style input selects the protocol. The block decodes a 4-bit address and updates or returns the addressed register. The data bus is split into an input word, an output word and an output-enable, and a tri-state pad outside the block combines them.

A mode input selects between host operation and hardware operation. In host operation the bus works as described above. In hardware operation every bus cycle is ignored and the register bank keeps its contents. The write-strobe / qualifier pin then acts as a static control: it drives the transmit-all-ones command of channel 0. A register change or a read appears a few clock cycles after the strobe edge that causes it, because of the two-flop synchroniser. The processor must respect this in its strobe timing.

Top module: `hbus_regif`

## Requirements
- R1: While `host_sel` is 1 (hardware operation, which is also the reset and floating state), `bus_doe` stays 0 whatever the strobes do.
- R2: In hardware operation `taos_ch0` follows the `wr_rw` pin, with two to four clock cycles of delay. In host operation `taos_ch0` is 0.
- R3: With `style_sel` = 0 (strobe style), the register at `addr` takes the value of `bus_din` when the synchronised `wr_rw` goes from 0 to 1.
- R4: With `style_sel` = 0, `bus_doe` is 1 and `bus_dout` carries the addressed register while the synchronised `rd_ds_n` is 0.
- R5: With `style_sel` = 1 (qualifier style), a falling edge of `rd_ds_n` while `wr_rw` = 1 starts a read. `bus_doe` is 1 and `bus_dout` carries the addressed register until `rd_ds_n` returns to 1.
- R6: With `style_sel` = 1, a falling edge of `rd_ds_n` while `wr_rw` = 0 writes `bus_din` into the addressed register. Toggling `wr_rw` while `rd_ds_n` is 1 writes nothing.
- R7: `bus_doe` is 1 only during an active read in host operation. It is never 1 unless `rd_ds_n` was 0 two clock cycles earlier.
- R8: Registers exist at addresses 0 to NUM_REGS-1 (0..5 by default). A read of any other address returns 0x00, and a write to it changes nothing.
- R9: A change of `style_sel` while a strobe is held active takes effect only after all strobes are released. The cycle in progress completes under the old style.
- R10: After reset, every register reads 0x00, `cfg_out` is 0 and `bus_doe` is 0.
- R11: In hardware operation the registers keep their values. Bus activity neither reads nor changes them, and they read back unchanged after a return to host operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 1 | 0 = host operation (bus active), 1 = hardware operation |
| style_sel | input | 1 | 0 = separate read/write strobes, 1 = data strobe plus read/write qualifier |
| addr | input | ADDR_W | Register address |
| rd_ds_n | input | 1 | Active-low read strobe or data strobe |
| wr_rw | input | 1 | Active-low write strobe, read/write qualifier (1 = read), or transmit-all-ones command in hardware operation |
| bus_din | input | DATA_W | Data bus value from the pad |
| bus_dout | output | DATA_W | Read data for the pad (0 when not driving) |
| bus_doe | output | 1 | Pad output enable; 0 means high-impedance |
| taos_ch0 | output | 1 | Transmit-all-ones command for channel 0 |
| cfg_out | output | NUM_REGS*DATA_W | Register contents, register 0 in the low byte |

## Verification
Two functions can coincide: a change of protocol style and a bus cycle that is still running. The bench holds one strobe active and flips `style_sel` in the middle of the cycle. It then checks that the cycle finishes under the style in force when it began. A held write strobe must still store its data on release. A held read must keep the bus driven with the correct byte. The next cycle must then follow the new style.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

    typedef enum logic {
        STY_STROBE = 1'b0,
        STY_QUAL   = 1'b1
    } bus_style_e;

    typedef struct packed {
        logic host_sel;
        logic style_sel;
        logic wr_rw;
        logic rd_ds_n;
    } pin_vec_t;

    localparam pin_vec_t PIN_IDLE = '{host_sel: 1'b1, style_sel: 1'b0,
                                      wr_rw: 1'b1, rd_ds_n: 1'b1};

    typedef struct packed {
        logic wr_en;
        logic rd_act;
    } bus_cmd_t;

    function automatic logic addr_mapped(input int unsigned a, input int unsigned nreg);
        return a < nreg;
    endfunction

endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
    parameter int WIDTH = 4,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/hbus_proto.sv
module hbus_proto
    import hbus_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       host,
    input  bus_style_e style_pin,
    input  logic       rd_s,
    input  logic       wr_s,
    output bus_style_e style_q,
    output bus_cmd_t   cmd
);
    logic rd_prev, wr_prev, qual_rd_q;
    logic rd_fall, wr_rise, idle;

    assign rd_fall = rd_prev & ~rd_s;
    assign wr_rise = ~wr_prev & wr_s;
    // All strobes released: in qualifier style the wr_rw pin is not a strobe
    assign idle    = rd_s & ((style_q == STY_QUAL) | wr_s);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_prev   <= 1'b1;
            wr_prev   <= 1'b1;
            style_q   <= STY_STROBE;
            qual_rd_q <= 1'b0;
        end else begin
            rd_prev <= rd_s;
            wr_prev <= wr_s;
            if (idle)
                style_q <= style_pin;
            if (rd_s)
                qual_rd_q <= 1'b0;
            else if (rd_fall && style_q == STY_QUAL && wr_s)
                qual_rd_q <= 1'b1;
        end
    end

    always_comb begin
        cmd = '0;
        if (host) begin
            if (style_q == STY_STROBE) begin
                cmd.rd_act = ~rd_s;
                cmd.wr_en  = wr_rise;
            end else begin
                cmd.rd_act = ~rd_s & qual_rd_q;
                cmd.wr_en  = rd_fall & ~wr_s;
            end
        end
    end
endmodule

// File: rtl/hbus_regbank.sv
module hbus_regbank
    import hbus_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 6
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wr_data,
    output logic [DATA_W-1:0]          rd_data,
    output logic [NUM_REGS*DATA_W-1:0] cfg_flat
);
    logic [DATA_W-1:0] regs [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[i] <= '0;
            else if (wr_en && int'(addr) == i)
                regs[i] <= wr_data;
        end
        assign cfg_flat[i*DATA_W +: DATA_W] = regs[i];
    end

    always_comb begin
        rd_data = '0;
        if (addr_mapped(int'(addr), NUM_REGS)) begin
            for (int i = 0; i < NUM_REGS; i++)
                if (int'(addr) == i)
                    rd_data = regs[i];
        end
    end
endmodule

// File: rtl/hbus_regif.sv
module hbus_regif
    import hbus_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 6
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       host_sel,
    input  logic                       style_sel,
    input  logic [ADDR_W-1:0]          addr,
    input  logic                       rd_ds_n,
    input  logic                       wr_rw,
    input  logic [DATA_W-1:0]          bus_din,
    output logic [DATA_W-1:0]          bus_dout,
    output logic                       bus_doe,
    output logic                       taos_ch0,
    output logic [NUM_REGS*DATA_W-1:0] cfg_out
);
    localparam int PIN_W = $bits(pin_vec_t);

    pin_vec_t          pins_raw, pins_s;
    bus_style_e        style_q;
    bus_cmd_t          cmd;
    logic [DATA_W-1:0] rd_data;
    logic              hw_s;

    assign pins_raw = '{host_sel: host_sel, style_sel: style_sel,
                        wr_rw: wr_rw, rd_ds_n: rd_ds_n};

    hbus_sync #(.WIDTH(PIN_W), .RST_VAL(PIN_IDLE)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pins_raw),
        .q   (pins_s)
    );

    assign hw_s = pins_s.host_sel;

    hbus_proto u_proto (
        .clk       (clk),
        .rst       (rst),
        .host      (~hw_s),
        .style_pin (bus_style_e'(pins_s.style_sel)),
        .rd_s      (pins_s.rd_ds_n),
        .wr_s      (pins_s.wr_rw),
        .style_q   (style_q),
        .cmd       (cmd)
    );

    hbus_regbank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cmd.wr_en),
        .addr     (addr),
        .wr_data  (bus_din),
        .rd_data  (rd_data),
        .cfg_flat (cfg_out)
    );

    assign bus_doe  = cmd.rd_act;
    assign bus_dout = cmd.rd_act ? rd_data : '0;
    assign taos_ch0 = hw_s & pins_s.wr_rw;
endmodule

// File: rtl/hbus_regif_chk.sv
module hbus_regif_chk #(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 6
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       rd_ds_n,
    input logic [ADDR_W-1:0]          addr,
    input logic                       bus_doe,
    input logic [DATA_W-1:0]          bus_dout,
    input logic                       taos_ch0,
    input logic [NUM_REGS*DATA_W-1:0] cfg_out,
    input logic                       hw_s
);
    a_r1_hw_no_drive: assert property (@(posedge clk) disable iff (rst)
        hw_s |-> !bus_doe);

    a_r2_host_taos_low: assert property (@(posedge clk) disable iff (rst)
        !hw_s |-> !taos_ch0);

    a_r7_doe_needs_strobe: assert property (@(posedge clk) disable iff (rst)
        bus_doe |-> !$past(rd_ds_n, 2));

    a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_doe && int'(addr) >= NUM_REGS) |-> bus_dout == '0);

    a_r10_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (cfg_out == '0 && !bus_doe));

    a_r11_hw_regs_kept: assert property (@(posedge clk) disable iff (rst)
        $past(hw_s) |-> $stable(cfg_out));
endmodule

bind hbus_regif hbus_regif_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .rd_ds_n  (rd_ds_n),
    .addr     (addr),
    .bus_doe  (bus_doe),
    .bus_dout (bus_dout),
    .taos_ch0 (taos_ch0),
    .cfg_out  (cfg_out),
    .hw_s     (hw_s)
);

// File: tb/hbus_regif_bench.sv
`timescale 1ns/1ps
module hbus_regif_bench;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int NR = 6;
    localparam int NA = 1 << AW;

    logic          clk = 1'b0;
    logic          rst;
    logic          host_sel, style_sel, rd_ds_n, wr_rw;
    logic [AW-1:0] addr;
    logic [DW-1:0] bus_din, bus_dout;
    logic          bus_doe, taos_ch0;
    logic [NR*DW-1:0] cfg_out;

    int total = 0;
    int bad   = 0;
    logic [DW-1:0] model [NA];

    always #2 clk = ~clk;

    hbus_regif #(.ADDR_W(AW), .DATA_W(DW), .NUM_REGS(NR)) u_hbus_regif (
        .clk(clk), .rst(rst), .host_sel(host_sel), .style_sel(style_sel),
        .addr(addr), .rd_ds_n(rd_ds_n), .wr_rw(wr_rw), .bus_din(bus_din),
        .bus_dout(bus_dout), .bus_doe(bus_doe), .taos_ch0(taos_ch0),
        .cfg_out(cfg_out)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic model_wr(input int a, input logic [DW-1:0] d);
        if (a < NR) model[a] = d;
    endtask

    task automatic strobe_write(input int a, input logic [DW-1:0] d);
        addr = AW'(a); bus_din = d;
        cyc(1); wr_rw = 1'b0;
        cyc(4); wr_rw = 1'b1;
        cyc(4);
    endtask

    task automatic strobe_read(input int a, input logic [DW-1:0] e, input string req);
        addr = AW'(a);
        cyc(1); rd_ds_n = 1'b0;
        cyc(4);
        chk(req, bus_doe, 1);
        chk(req, bus_dout, e);
        rd_ds_n = 1'b1;
        cyc(4);
        chk("R7 idle after read", bus_doe, 0);
    endtask

    task automatic qual_write(input int a, input logic [DW-1:0] d);
        addr = AW'(a); bus_din = d; wr_rw = 1'b0;
        cyc(3); rd_ds_n = 1'b0;
        cyc(4); rd_ds_n = 1'b1;
        cyc(3); wr_rw = 1'b1;
        cyc(3);
    endtask

    task automatic qual_read(input int a, input logic [DW-1:0] e, input string req);
        addr = AW'(a); wr_rw = 1'b1;
        cyc(3); rd_ds_n = 1'b0;
        cyc(5);
        chk(req, bus_doe, 1);
        chk(req, bus_dout, e);
        rd_ds_n = 1'b1;
        cyc(4);
        chk("R7 idle after qual read", bus_doe, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NA; i++) model[i] = '0;
        rst = 1'b1; host_sel = 1'b0; style_sel = 1'b0;
        rd_ds_n = 1'b1; wr_rw = 1'b1; addr = '0; bus_din = '0;
        cyc(5); rst = 1'b0; cyc(4);

        // R10 reset state
        chk("R10 doe", bus_doe, 0);
        chk("R10 cfg", cfg_out, 0);
        chk("R2 taos host", taos_ch0, 0);
        for (int a = 0; a < NA; a++) strobe_read(a, 8'h00, "R10 read zero");

        // R3/R8 strobe-style write sweep, R4 read sweep
        for (int a = 0; a < NA; a++) begin
            logic [DW-1:0] d;
            d = DW'((a * 29 + 19) ^ 8'hA5);
            strobe_write(a, d);
            model_wr(a, d);
        end
        for (int i = 0; i < NR; i++)
            chk("R3 cfg_out", cfg_out[i*DW +: DW], model[i]);
        for (int a = 0; a < NA; a++)
            strobe_read(a, model[a], a < NR ? "R4 strobe read" : "R8 unmapped strobe read");

        // R2 taos stays low in host operation while write strobe is low
        addr = 4'd0; bus_din = model[0]; wr_rw = 1'b0;
        cyc(4);
        chk("R2 taos low in host", taos_ch0, 0);
        wr_rw = 1'b1; cyc(4);

        // R9 style change during held write strobe
        addr = 4'd3; bus_din = 8'h3C; wr_rw = 1'b0;
        cyc(4); style_sel = 1'b1;
        cyc(4); wr_rw = 1'b1;
        cyc(4);
        model_wr(3, 8'h3C);
        chk("R9 held write kept old style", cfg_out[3*DW +: DW], 8'h3C);
        qual_read(3, 8'h3C, "R9 new style after release");

        // R6/R8 qualifier-style write sweep, R5 read sweep
        for (int a = 0; a < NA; a++) begin
            logic [DW-1:0] d;
            d = DW'(a * 53 + 124);
            qual_write(a, d);
            model_wr(a, d);
        end
        for (int a = 0; a < NA; a++)
            qual_read(a, model[a], a < NR ? "R5 qual read" : "R8 unmapped qual read");

        // R6 qualifier toggles without data strobe write nothing
        addr = 4'd0; bus_din = 8'hEE;
        cyc(1); wr_rw = 1'b0; cyc(4); wr_rw = 1'b1; cyc(4);
        chk("R6 no write without strobe", cfg_out[0 +: DW], model[0]);

        // R9 style change during held read
        style_sel = 1'b0; cyc(4);
        addr = 4'd1;
        cyc(1); rd_ds_n = 1'b0; cyc(4);
        style_sel = 1'b1; cyc(4);
        chk("R9 held read doe", bus_doe, 1);
        chk("R9 held read data", bus_dout, model[1]);
        rd_ds_n = 1'b1; cyc(4);
        chk("R9 released doe", bus_doe, 0);
        qual_read(1, model[1], "R9 qual after release");
        style_sel = 1'b0; cyc(4);

        // R1/R2/R11 hardware operation
        host_sel = 1'b1; cyc(4);
        wr_rw = 1'b0; cyc(4);
        chk("R2 taos low", taos_ch0, 0);
        wr_rw = 1'b1; cyc(4);
        chk("R2 taos high", taos_ch0, 1);
        addr = 4'd2; bus_din = 8'hFF;
        wr_rw = 1'b0; cyc(4); wr_rw = 1'b1; cyc(4);
        rd_ds_n = 1'b0; cyc(4);
        chk("R1 no drive in hardware", bus_doe, 0);
        rd_ds_n = 1'b1; cyc(4);
        chk("R11 regs kept", cfg_out[2*DW +: DW], model[2]);
        host_sel = 1'b0; cyc(4);
        chk("R2 taos back low", taos_ch0, 0);
        for (int a = 0; a < NR; a++) strobe_read(a, model[a], "R11 readback after hardware");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule